// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Fixed Off-Time Chopping

This block is the digital controller for one full-bridge that drives a brushed DC motor. Its inputs are a direction bit (`phase_i`), a drive/brake bit (`pwm_i`), a bridge enable, and a flag from an external comparator. The flag says that the voltage on the current-sense resistor has risen above the reference. From these inputs the block computes four gate commands, one for each switch. Each bridge side, or leg, is one high-side and low-side switch pair. When the inputs are stable, the commands follow a fixed truth table.

The block sequences every leg change through a dead-time interval in which both switches of the leg are off. This means a high side and a low side of the same leg are never on together.

While the bridge is driving, a rise of the synchronised comparator flag triggers a slow-decay phase. The flag is honoured only after a blanking window that follows the start of drive. In slow decay both low sides conduct for a fixed number of clock cycles, and the direction and drive inputs are ignored for that time. When the count runs out, normal truth-table control resumes. Dropping the enable cancels decay at once and turns every switch off.

All time intervals are parameters in clock cycles:
- `DEAD_CYC`: dead time
- `BLANK_CYC`: blanking window
- `OFF_CYC`: off time

Top module: `hbridge_chopper`

## Requirements
- R1: With `enable_i` low, all four gate outputs are 0 one clock after the low enable is sampled, and they stay 0 for every value of `phase_i`, `pwm_i` and `over_ref_i`. During reset all four outputs are 0.
- R2: With enable high and `pwm_i` = 0, the steady output is ls1 = ls2 = 1 and hs1 = hs2 = 0 (brake), for both values of `phase_i`.
- R3: With enable high, `phase_i` = 1 and `pwm_i` = 1, the steady output is hs1 = 1, ls2 = 1, ls1 = 0, hs2 = 0.
- R4: With enable high, `phase_i` = 0 and `pwm_i` = 1, the steady output is hs2 = 1, ls1 = 1, hs1 = 0, ls2 = 0.
- R5: In no clock cycle are the high-side and low-side commands of the same leg both 1.
- R6: A switch is turned on only after both switches of its leg have been off for at least `DEAD_CYC` consecutive cycles. Going from brake to R3 drive, hs1 rises exactly `DEAD_CYC`+2 clocks after the inputs change.
- R7: Decay starts when `over_ref_i` is sampled high while the bridge is driving (`pwm_i` = 1) and the blanking window has elapsed. In decay, both low sides turn on and both high sides turn off. The flag passes two synchroniser stages, and the decay state is entered on the third clock edge after the flag is applied.
- R8: For the whole decay period, changes on `phase_i` and `pwm_i` have no effect on the gate outputs.
- R9: Decay lasts `OFF_CYC` cycles. Then the truth table applies again: with R3 drive, hs1 rises again exactly `OFF_CYC`+`DEAD_CYC`+5 clocks after the comparator flag was applied.
- R10: A comparator flag is ignored until `pwm_i` has been 1 for more than `BLANK_CYC` cycles. A high flag that is synchronised only within that window does not start decay.
- R11: Dropping enable during decay ends decay at once. When enable returns, the bridge follows the truth table, not the cancelled decay.
- R12: A comparator flag while the bridge is braking has no effect and leaves no pending trigger behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Bridge enable; low turns every switch off |
| phase_i | input | 1 | Direction select |
| pwm_i | input | 1 | 1 = drive, 0 = brake |
| over_ref_i | input | 1 | Asynchronous comparator flag, sense above reference |
| hs1_o | output | 1 | High-side gate command, leg 1 |
| ls1_o | output | 1 | Low-side gate command, leg 1 |
| hs2_o | output | 1 | High-side gate command, leg 2 |
| ls2_o | output | 1 | Low-side gate command, leg 2 |

## Verification
The hardest state to reach from the ports is an input change that falls inside an active decay, with the decay then cut short by enable. The comparator flag passes a synchroniser and a blanking window, so the stimulus first holds forward drive well past `BLANK_CYC` cycles, then pulses the flag for one clock. From that point every later action is scheduled by counting clocks. Inputs are toggled and restored mid-decay, and the exact clock in which hs1 returns is measured. A second decay is started and broken by dropping enable. A separate run holds the flag high only inside the blanking window to show that it is discarded.

// File: rtl/hbridge_ctl_pkg.sv
package hbridge_ctl_pkg;

  // request for one bridge leg
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_LOW  = 2'd1,
    LEG_HIGH = 2'd2
  } leg_req_e;

  typedef enum logic {
    CH_RUN   = 1'b0,
    CH_DECAY = 1'b1
  } chop_st_e;

endpackage

// File: rtl/hbridge_flag_sync.sv
module hbridge_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
  import hbridge_ctl_pkg::*;
#(
  parameter int OFF_CYC   = 40,
  parameter int BLANK_CYC = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     phase_i,
  input  logic     pwm_i,
  input  logic     trip_i,
  output leg_req_e req1_o,
  output leg_req_e req2_o
);

  localparam int OW = (OFF_CYC > 1) ? $clog2(OFF_CYC) : 1;
  localparam int BW = $clog2(BLANK_CYC + 1);

  chop_st_e        st_q, st_d;
  logic [OW-1:0]   off_q, off_d;
  logic [BW-1:0]   blk_q, blk_d;
  logic            off_ce, blk_ce;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    off_d = off_q;
    blk_d = blk_q;
    if (!en_i) begin
      st_d  = CH_RUN;
      off_d = '0;
      blk_d = '0;
    end else if (st_q == CH_DECAY) begin
      blk_d = '0;
      if (off_q == OW'(OFF_CYC - 1)) begin
        st_d  = CH_RUN;
        off_d = '0;
      end else begin
        off_d = off_q + 1'b1;
      end
    end else begin
      if (!pwm_i) begin
        blk_d = '0;
      end else if (blk_q != BW'(BLANK_CYC)) begin
        blk_d = blk_q + 1'b1;
      end else if (trip_i) begin
        st_d  = CH_DECAY;
        off_d = '0;
      end
    end
  end

  assign off_ce = (off_d != off_q) || (st_d != st_q);
  assign blk_ce = (blk_d != blk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_RUN;
      off_q <= '0;
      blk_q <= '0;
    end else begin
      if (off_ce) begin
        st_q  <= st_d;
        off_q <= off_d;
      end
      if (blk_ce) blk_q <= blk_d;
    end
  end

  // truth table, overridden by decay and enable
  always_comb begin
    if (!en_i) begin
      req1_o = LEG_OFF;
      req2_o = LEG_OFF;
    end else if (st_q == CH_DECAY || !pwm_i) begin
      req1_o = LEG_LOW;
      req2_o = LEG_LOW;
    end else if (phase_i) begin
      req1_o = LEG_HIGH;
      req2_o = LEG_LOW;
    end else begin
      req1_o = LEG_LOW;
      req2_o = LEG_HIGH;
    end
  end

  // decay is only entered from an enabled drive state
  assert_decay_from_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == CH_DECAY) |-> $past(en_i && pwm_i && trip_i));

  // inputs ignored: both legs held low while decaying
  assert_decay_holds_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_DECAY && en_i) |-> (req1_o == LEG_LOW && req2_o == LEG_LOW));

  // enable low cancels decay on the next edge
  assert_enable_cancels_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == CH_RUN));

endmodule

// File: rtl/hbridge_leg_dt.sv
module hbridge_leg_dt
  import hbridge_ctl_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_req_e req_i,
  output logic     hs_o,
  output logic     ls_o
);

  localparam int DW = $clog2(DEAD_CYC + 1);

  logic          hs_q, hs_d, ls_q, ls_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          idle, ready;

  assign idle  = !hs_q && !ls_q;
  assign ready = (cnt_q == DW'(DEAD_CYC));

  // turn-off is immediate, turn-on waits for a full dead interval
  always_comb begin
    hs_d  = hs_q;
    ls_d  = ls_q;
    cnt_d = cnt_q;
    case (req_i)
      LEG_HIGH: begin
        if (ls_q) begin
          ls_d  = 1'b0;
          cnt_d = '0;
        end else if (idle) begin
          if (ready) hs_d  = 1'b1;
          else       cnt_d = cnt_q + 1'b1;
        end
      end
      LEG_LOW: begin
        if (hs_q) begin
          hs_d  = 1'b0;
          cnt_d = '0;
        end else if (idle) begin
          if (ready) ls_d  = 1'b1;
          else       cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        hs_d = 1'b0;
        ls_d = 1'b0;
        if (!idle)      cnt_d = '0;
        else if (!ready) cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hs_q  <= hs_d;
      ls_q  <= ls_d;
      cnt_q <= cnt_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  assert_no_shoot_through_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));

  assert_hs_after_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(!hs_q && !ls_q));

  assert_ls_after_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> $past(!hs_q && !ls_q));

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hbridge_ctl_pkg::*;
#(
  parameter int DEAD_CYC  = 4,
  parameter int BLANK_CYC = 8,
  parameter int OFF_CYC   = 40,
  parameter int SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic phase_i,
  input  logic pwm_i,
  input  logic over_ref_i,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o
);

  localparam int NLEG = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_n;
  logic       trip_s;
  leg_req_e   req [NLEG];
  logic       hs  [NLEG];
  logic       ls  [NLEG];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  hbridge_flag_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (over_ref_i),
    .sync_o  (trip_s)
  );

  hbridge_chop_ctrl #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .en_i    (enable_i),
    .phase_i (phase_i),
    .pwm_i   (pwm_i),
    .trip_i  (trip_s),
    .req1_o  (req[0]),
    .req2_o  (req[1])
  );

  for (genvar gi = 0; gi < NLEG; gi++) begin : g_leg
    hbridge_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .req_i  (req[gi]),
      .hs_o   (hs[gi]),
      .ls_o   (ls[gi])
    );
  end

  assign hs1_o = hs[0];
  assign ls1_o = ls[0];
  assign hs2_o = hs[1];
  assign ls2_o = ls[1];

  assert_disable_all_off_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !enable_i |=> !(hs1_o || ls1_o || hs2_o || ls2_o));

endmodule

// File: tb/hbridge_chopper_tb_top.sv
`timescale 1ns/1ps
module hbridge_chopper_tb_top;

  localparam int DEAD  = 4;
  localparam int BLANK = 8;
  localparam int OFFC  = 40;

  logic clk = 1'b0;
  logic rst_n, en, ph, pwm, ovr;
  logic hs1, ls1, hs2, ls2;
  int   checks = 0;
  int   bad    = 0;

  always #2.5 clk = ~clk;

  hbridge_chopper #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .OFF_CYC(OFFC), .SYNC_STG(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .phase_i(ph), .pwm_i(pwm),
    .over_ref_i(ovr), .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2)
  );

  // {hs1, ls1, hs2, ls2}
  function automatic logic [3:0] gates();
    return {hs1, ls1, hs2, ls2};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // leg monitor: shoot-through and dead interval (R5, R6)
  int offrun [2];
  logic pon [2];
  initial begin
    offrun[0] = 0; offrun[1] = 0; pon[0] = 1'b0; pon[1] = 1'b0;
    forever begin
      @(negedge clk);
      for (int l = 0; l < 2; l++) begin
        logic h, s;
        h = (l == 0) ? hs1 : hs2;
        s = (l == 0) ? ls1 : ls2;
        if (h && s) chk(1'b0, "R5 shoot-through", {h, s}, 0);
        if ((h || s) && !pon[l]) chk(offrun[l] >= DEAD, "R6 dead gap", offrun[l], DEAD);
        pon[l] = h || s;
        offrun[l] = (h || s) ? 0 : offrun[l] + 1;
      end
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; ph = 1'b0; pwm = 1'b0; ovr = 1'b0;
    cyc(3);
    chk(gates() == 4'b0000, "R1 reset state", gates(), 0);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_brake();
    en = 1'b1; ph = 1'b0; pwm = 1'b0;
    cyc(DEAD + 10);
    chk(gates() == 4'b0101, "R2 brake phase0", gates(), 4'b0101);
    ph = 1'b1;
    cyc(4);
    chk(gates() == 4'b0101, "R2 brake phase1", gates(), 4'b0101);
  endtask

  task automatic t_fwd_after_brake_flag();
    int rise = -1;
    ovr = 1'b1; cyc(1); ovr = 1'b0;       // flag while braking
    cyc(6);
    chk(gates() == 4'b0101, "R12 brake unchanged", gates(), 4'b0101);
    ph = 1'b1; pwm = 1'b1;
    for (int i = 1; i <= DEAD + 10; i++) begin
      cyc(1);
      if (hs1 && rise < 0) rise = i;
    end
    chk(rise == DEAD + 2, "R6 hs1 turn-on latency", rise, DEAD + 2);
    cyc(30);
    chk(gates() == 4'b1001, "R3 forward / R12 no pending trip", gates(), 4'b1001);
  endtask

  task automatic t_rev();
    ph = 1'b0;
    cyc(2 * DEAD + 6);
    chk(gates() == 4'b0110, "R4 reverse", gates(), 4'b0110);
  endtask

  task automatic t_blank();
    pwm = 1'b0; ph = 1'b1;
    cyc(DEAD + 6);
    pwm = 1'b1; ovr = 1'b1;               // flag only inside the window
    cyc(BLANK - 2);
    ovr = 1'b0;
    cyc(20);
    chk(gates() == 4'b1001, "R10 flag in blanking ignored", gates(), 4'b1001);
  endtask

  task automatic t_trip();
    int rise = -1;
    cyc(BLANK + 4);
    ovr = 1'b1;
    for (int i = 1; i <= OFFC + DEAD + 12; i++) begin
      cyc(1);
      if (i == 1) ovr = 1'b0;
      if (i == 3) chk(gates() == 4'b1001, "R7 still driving before entry", gates(), 4'b1001);
      if (i == 4) chk(hs1 == 1'b0, "R7 high side off at decay", hs1, 0);
      if (i == DEAD + 7) chk(gates() == 4'b0101, "R7 decay both low", gates(), 4'b0101);
      if (i == DEAD + 8) begin ph = 1'b0; pwm = 1'b0; end
      if (i == DEAD + 12) chk(gates() == 4'b0101, "R8 brake input ignored", gates(), 4'b0101);
      if (i == DEAD + 13) begin ph = 1'b0; pwm = 1'b1; end
      if (i == DEAD + 22) chk(gates() == 4'b0101, "R8 reverse input ignored", gates(), 4'b0101);
      if (i == DEAD + 23) begin ph = 1'b1; pwm = 1'b1; end
      if (hs1 && rise < 0 && i > 4) rise = i;
    end
    chk(rise == OFFC + DEAD + 5, "R9 decay length", rise, OFFC + DEAD + 5);
    chk(gates() == 4'b1001, "R9 truth table resumes", gates(), 4'b1001);
  endtask

  task automatic t_en_drop();
    cyc(BLANK + 10);
    ovr = 1'b1; cyc(1); ovr = 1'b0;
    cyc(10);
    chk(gates() == 4'b0101, "R11 in decay before drop", gates(), 4'b0101);
    en = 1'b0;
    cyc(1);
    chk(gates() == 4'b0000, "R11 drop gives all off", gates(), 0);
    for (int k = 0; k < 4; k++) begin
      ph = k[0]; pwm = k[1]; ovr = k[0];
      cyc(2);
      chk(gates() == 4'b0000, "R1 disabled any input", gates(), 0);
    end
    ovr = 1'b0; ph = 1'b1; pwm = 1'b1;
    cyc(8);
    en = 1'b1;
    cyc(2);
    chk(gates() == 4'b1001, "R11 no resumed decay", gates(), 4'b1001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_brake();
    t_fwd_after_brake_flag();
    t_rev();
    t_blank();
    t_trip();
    t_en_drop();
    cyc(5);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule